// File: doc/BRIEF.md
# Two-Stage Fetch Permission Checker

The block judges whether an instruction fetch may proceed when an address goes through two translation stages: guest paging, then a second-stage table owned by the hypervisor. It runs beside a page walker. As the walker reads each guest paging-structure entry or second-stage entry, it hands the entry over with a one-cycle strobe. The checker keeps sticky summaries of the permission bits it sees. When the walker signals the end of the walk, the checker gives a registered verdict and a reason code.

Two things steer the guest side: the current privilege level and the paging and PAE enables. The first stage sorts the linear address into a supervisor-mode or a user-mode address. When mode-based execution is enabled, the second stage uses that class to choose which execute bit it consults. A guest denial outranks a second-stage denial. A walk that ends with no second-stage entry at all is refused.

Top module: `ifetch_perm_chk`

## Requirements
- R1: While reset is asserted, and after it, until the first done, `res_vld_o`=0, `allow_o`=0 and `reason_o`=00.
- R2: The verdict appears on the clock edge after the edge that samples `done_i`, together with a one-cycle `res_vld_o` pulse. `allow_o` and `reason_o` hold their values until the next done.
- R3: `start_i` clears all accumulated state. An entry strobed in the same cycle as `start_i` counts as the first level. Guest and second-stage strobes may arrive in any interleaving, including in the same cycle. An entry strobed in the same cycle as `done_i` is included in the verdict.
- R4: Guest entry bit 2 is the user flag. When paging is on, an address is supervisor-mode if that bit is 0 in any guest level, and user-mode otherwise. When paging is off, the address is user-mode and guest entries are ignored. A fetch at privilege level 3 from a supervisor-mode address is denied with reason 01.
- R5: When paging and PAE are both on, guest entry bit 63 set in any level denies the fetch with reason 01.
- R6: When mode-based execution is off, second-stage bit 2 clear in any level denies the fetch with reason 10.
- R7: When mode-based execution is on, a user-mode address is denied with reason 10 if second-stage bit 10 is clear in any level. A supervisor-mode address is denied with reason 10 if second-stage bit 2 is clear in any level.
- R8: A done with no second-stage level accumulated denies the fetch with reason 10.
- R9: When both stages would deny, the reason is 01.
- R10: `allow_o` is 1 exactly when `reason_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new walk and clears the accumulators |
| gst_vld_i | input | 1 | Guest entry strobe |
| gst_entry_i | input | 64 | Guest paging-structure entry |
| s2_vld_i | input | 1 | Second-stage entry strobe |
| s2_entry_i | input | 64 | Second-stage entry |
| done_i | input | 1 | End of walk; requests the verdict |
| cpl_i | input | 2 | Current privilege level |
| pg_en_i | input | 1 | Guest paging enabled |
| pae_en_i | input | 1 | PAE enabled (no-execute bit active) |
| mbx_en_i | input | 1 | Mode-based second-stage execute select |
| res_vld_o | output | 1 | One-cycle verdict strobe |
| allow_o | output | 1 | Fetch allowed |
| reason_o | output | 2 | 00 allowed, 01 guest denial, 10 second-stage denial |

## Verification
Two functions can land in the same cycle. The first is accumulation from both stages. The second is the closing done, which must fold in an entry arriving alongside it. A third of the walks in the sweep present the guest and second-stage entries as pairs, with start on the first pair and done on the last pair. The remaining walks present them in guest-first and stage-first order, with done in a cycle of its own. Every case in the sweep is compared against a verdict that the bench computes from the bit rules. The sweep covers every privilege level and every enable combination, one or two guest levels, and zero to two second-stage levels.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    RSN_OK     = 2'b00,
    RSN_GUEST  = 2'b01,
    RSN_STAGE2 = 2'b10
  } rsn_e;
endpackage

// File: rtl/ifc_sticky_or.sv
// Sticky OR accumulator: clear on clr_i, OR in bits_i on vld_i (same-cycle vld counts after clear).
module ifc_sticky_or #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         vld_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;
  logic         en;

  always_comb begin
    q_nxt = clr_i ? '0 : q_r;
    if (vld_i) q_nxt = q_nxt | bits_i;
  end

  assign en = clr_i | vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q_o   = q_r;
  assign nxt_o = q_nxt;
endmodule

// File: rtl/ifc_verdict.sv
module ifc_verdict
  import ifc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_i,
  input  logic [1:0] cpl_i,
  input  logic       pg_en_i,
  input  logic       pae_en_i,
  input  logic       mbx_en_i,
  input  logic       g_sup_i,
  input  logic       g_nx_i,
  input  logic       s2_seen_i,
  input  logic       s2_x_clr_i,
  input  logic       s2_ux_clr_i,
  output logic       res_vld_o,
  output logic       allow_o,
  output logic [1:0] reason_o
);
  logic sup_addr, priv_deny, nx_deny, g_deny, s2_deny;
  rsn_e rsn_nxt;
  logic vld_r, allow_r;
  rsn_e rsn_r;

  always_comb begin
    sup_addr  = pg_en_i & g_sup_i;
    priv_deny = sup_addr & (cpl_i == 2'd3);
    nx_deny   = pg_en_i & pae_en_i & g_nx_i;
    g_deny    = priv_deny | nx_deny;
    if (!s2_seen_i)                 s2_deny = 1'b1;
    else if (mbx_en_i && !sup_addr) s2_deny = s2_ux_clr_i;
    else                            s2_deny = s2_x_clr_i;
    if (g_deny)       rsn_nxt = RSN_GUEST;
    else if (s2_deny) rsn_nxt = RSN_STAGE2;
    else              rsn_nxt = RSN_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_r <= 1'b0;
    else        vld_r <= done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_r <= 1'b0;
      rsn_r   <= RSN_OK;
    end else if (done_i) begin
      allow_r <= (rsn_nxt == RSN_OK);
      rsn_r   <= rsn_nxt;
    end
  end

  assign res_vld_o = vld_r;
  assign allow_o   = allow_r;
  assign reason_o  = rsn_r;

  // R2: verdict strobe follows done by one cycle
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o == $past(done_i));
  // R2: outputs hold without done
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ($stable(allow_o) && $stable(reason_o)));
  // R4/R9: user-level fetch of a supervisor page is a guest denial
  p_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pg_en_i && cpl_i == 2'd3 && g_sup_i) |=> (reason_o == 2'b01 && !allow_o));
  // R8: no second-stage level and no guest denial gives reason 10
  p_nolevel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !s2_seen_i && !(pg_en_i && pae_en_i && g_nx_i) &&
     !(pg_en_i && g_sup_i && cpl_i == 2'd3)) |=> (reason_o == 2'b10));
  // R10: allow exactly when reason is 00
  p_enc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (allow_o == (reason_o == 2'b00)));
endmodule

// File: rtl/ifetch_perm_chk.sv
module ifetch_perm_chk
  import ifc_pkg::*;
#(
  parameter int ENTRY_W  = 64,
  parameter int G_US_BIT = 2,
  parameter int G_NX_BIT = 63,
  parameter int S2_X_BIT = 2,
  parameter int S2_UX_BIT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               gst_vld_i,
  input  logic [ENTRY_W-1:0] gst_entry_i,
  input  logic               s2_vld_i,
  input  logic [ENTRY_W-1:0] s2_entry_i,
  input  logic               done_i,
  input  logic [1:0]         cpl_i,
  input  logic               pg_en_i,
  input  logic               pae_en_i,
  input  logic               mbx_en_i,
  output logic               res_vld_o,
  output logic               allow_o,
  output logic [1:0]         reason_o
);
  localparam int G_N  = 2;  // {nx seen, supervisor seen}
  localparam int S2_N = 3;  // {ux clear, x clear, level seen}

  logic [G_N-1:0]  g_bits, g_q, g_nxt;
  logic [S2_N-1:0] s_bits, s_q, s_nxt;
  logic            g_vld;

  // guest entries are ignored while paging is off (R4)
  assign g_vld  = gst_vld_i & pg_en_i;
  assign g_bits = {gst_entry_i[G_NX_BIT], ~gst_entry_i[G_US_BIT]};
  assign s_bits = {~s2_entry_i[S2_UX_BIT], ~s2_entry_i[S2_X_BIT], 1'b1};

  ifc_sticky_or #(.N(G_N)) u_gacc (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .vld_i(g_vld),
    .bits_i(g_bits), .q_o(g_q), .nxt_o(g_nxt));

  ifc_sticky_or #(.N(S2_N)) u_sacc (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .vld_i(s2_vld_i),
    .bits_i(s_bits), .q_o(s_q), .nxt_o(s_nxt));

  ifc_verdict u_vrd (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .cpl_i(cpl_i),
    .pg_en_i(pg_en_i), .pae_en_i(pae_en_i), .mbx_en_i(mbx_en_i),
    .g_sup_i(g_nxt[0]), .g_nx_i(g_nxt[1]),
    .s2_seen_i(s_nxt[0]), .s2_x_clr_i(s_nxt[1]), .s2_ux_clr_i(s_nxt[2]),
    .res_vld_o(res_vld_o), .allow_o(allow_o), .reason_o(reason_o));

  // R3: start empties both accumulators when no strobe accompanies it
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !gst_vld_i && !s2_vld_i) |=> (g_q == '0 && s_q == '0));
endmodule

// File: tb/sim_ifetch_perm_chk.sv
module sim_ifetch_perm_chk;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, gst_vld_i = 0, s2_vld_i = 0, done_i = 0;
  logic [63:0] gst_entry_i = '0, s2_entry_i = '0;
  logic [1:0] cpl_i = 0;
  logic pg_en_i = 0, pae_en_i = 0, mbx_en_i = 0;
  logic res_vld_o, allow_o;
  logic [1:0] reason_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  ifetch_perm_chk u0 (.*);

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: %s", tag, msg); end
  endtask

  function automatic logic [63:0] gent(input bit us, input bit nx);
    logic [63:0] e = 64'h0000_0F00_0000_0003;
    e[2] = us; e[63] = nx; return e;
  endfunction
  function automatic logic [63:0] sent(input bit x, input bit ux);
    logic [63:0] e = 64'h0000_0000_0000_00F1;
    e[2] = x; e[10] = ux; return e;
  endfunction

  // one walk; gc bit 2l = user flag, 2l+1 = nx; ec bit 2l = x, 2l+1 = ux
  task automatic walk(input int cpl, input bit pg, input bit pae, input bit mbx,
                      input int ng, input int gc, input int ne, input int ec, input int mode);
    bit sup, gnx, gden, sden;
    int exp_r, len;
    string tag;
    logic [1:0] r0; logic a0;
    sup = 0; gnx = 0; sden = 0;
    for (int l = 0; l < ng; l++) begin
      if (!gc[2*l]) sup = 1;
      if (gc[2*l+1]) gnx = 1;
    end
    sup  = sup & pg;                         // R4 paging off: user-mode
    gden = (pg && pae && gnx) || (sup && cpl == 3);
    if (ne == 0) sden = 1;                   // R8
    else for (int l = 0; l < ne; l++)
      if (mbx && !sup) begin if (!ec[2*l+1]) sden = 1; end   // R7 user
      else if (!ec[2*l]) sden = 1;                           // R6 / R7 supervisor
    exp_r = gden ? 1 : (sden ? 2 : 0);       // R9 priority
    if (gden && sden) tag = "R9";
    else if (pg && pae && gnx) tag = "R5";
    else if (gden) tag = "R4";
    else if (ne == 0) tag = "R8";
    else if (mbx) tag = "R7";
    else tag = "R6";
    @(negedge clk);
    cpl_i = 2'(cpl); pg_en_i = pg; pae_en_i = pae; mbx_en_i = mbx;
    if (mode == 0) begin
      // R3: paired strobes, start on first pair, done on last pair
      len = (ng > ne) ? ng : ne;
      for (int k = 0; k < len; k++) begin
        start_i = (k == 0); done_i = (k == len - 1);
        gst_vld_i = (k < ng); gst_entry_i = gent(gc[2*k], gc[2*k+1]);
        s2_vld_i = (k < ne);  s2_entry_i = sent(ec[2*k], ec[2*k+1]);
        @(negedge clk);
      end
    end else begin
      // R3: sequential interleavings, guest-first or stage-first
      start_i = 1; @(negedge clk); start_i = 0;
      for (int p = 0; p < 2; p++) begin
        bit gphase = (p == 0) == (mode == 1);
        int n = gphase ? ng : ne;
        for (int k = 0; k < n; k++) begin
          gst_vld_i = gphase; s2_vld_i = !gphase;
          gst_entry_i = gent(gc[2*k], gc[2*k+1]);
          s2_entry_i  = sent(ec[2*k], ec[2*k+1]);
          @(negedge clk);
        end
        gst_vld_i = 0; s2_vld_i = 0;
      end
      done_i = 1; @(negedge clk);
    end
    start_i = 0; done_i = 0; gst_vld_i = 0; s2_vld_i = 0;
    // R10: allow tracks reason 00
    chk(res_vld_o && reason_o == 2'(exp_r) && allow_o == (exp_r == 0), tag,
        $sformatf("vld=%0b allow=%0b reason=%0d exp allow=%0b reason=%0d (cpl=%0d pg=%0b pae=%0b mbx=%0b ng=%0d gc=%0h ne=%0d ec=%0h m=%0d)",
                  res_vld_o, allow_o, reason_o, exp_r == 0, exp_r, cpl, pg, pae, mbx, ng, gc, ne, ec, mode));
    r0 = reason_o; a0 = allow_o;
    @(negedge clk);
    chk(!res_vld_o && reason_o == r0 && allow_o == a0, "R2",
        $sformatf("vld=%0b allow=%0b reason=%0d exp vld=0 allow=%0b reason=%0d",
                  res_vld_o, allow_o, reason_o, a0, r0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_vld_o && !allow_o && reason_o == 2'b00, "R1",
        $sformatf("in reset vld=%0b allow=%0b reason=%0d exp 0 0 0", res_vld_o, allow_o, reason_o));
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!res_vld_o && !allow_o && reason_o == 2'b00, "R1",
        $sformatf("after reset vld=%0b allow=%0b reason=%0d exp 0 0 0", res_vld_o, allow_o, reason_o));
    begin
      int idx = 0;
      for (int cpl = 0; cpl < 4; cpl++)
        for (int cfg = 0; cfg < 8; cfg++)
          for (int ng = 1; ng <= 2; ng++)
            for (int gc = 0; gc < (1 << (2*ng)); gc++)
              for (int ne = 0; ne <= 2; ne++)
                for (int ec = 0; ec < (1 << (2*ne)); ec++) begin
                  walk(cpl, cfg[0], cfg[1], cfg[2], ng, gc, ne, ec, idx % 3);
                  idx++;
                end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule